// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a single-clock static memory organised as byte lanes of nine bits (eight data bits plus a parity bit). Every control and address input except output enable, burst-order select and sleep is registered on the rising clock edge. An access begins when one of two address strobes is sampled low. The processor strobe always starts a read and is honoured only while the first select is low. The controller strobe starts a read or a write, chosen by the write controls. Once a burst is open, an advance input steps the two low address bits through a four-beat sequence, or holds them in place when it stays high.

Writes cover all lanes through a global write, or single lanes through a byte-write enable together with per-lane enables. Read data is registered and appears one clock after the access edge. An asynchronous output enable gates a drive flag, which stands in for a tri-state pad. A sleep input turns the drive off at once, keeps the memory contents and freezes the burst. After sleep falls, a fixed wake-up window rejects strobes and reports each rejected one on an error flag.

Top module: `sbsram_core`

## Requirements
- R1: On an edge where a strobe opens a new access, the part is selected only when sel_a_n=0, sel_b=1 and sel_c_n=0. Any other combination closes the burst: nothing is written, and dout_en is 0 after that edge.
- R2: While sel_a_n is high, a low strb_cpu_n is ignored. If strb_ctl_n is high on that edge, the edge behaves as a burst continue.
- R3: A selected processor-strobe start reads the external address whatever the write controls say. Its data is on dout after that edge, and the array is left unchanged.
- R4: The write decode works as follows. gwr_n=0 writes all lanes. gwr_n=1 with bwr_n=0 writes each lane whose lane_we_n bit is 0. gwr_n=1 with bwr_n=1, or with every lane_we_n bit at 1, gives a read. A controller-strobe start and every continue edge follow this decode.
- R5: Lane i is din/dout bits [9i+8:9i]. Lanes that a write does not enable keep their old contents.
- R6: With both strobes high during an open burst, step_n=0 moves to the next burst address and performs the access there. step_n=1 repeats the access at the current address.
- R7: Beat k (k = 0..3, modulo 4) uses low address bits base+k when order_ilv=0, and base XOR k when order_ilv=1. The upper address bits stay fixed for the whole burst.
- R8: step_n is ignored on the edge where a processor strobe is accepted, so that edge accesses the external address itself.
- R9: dout_en equals (oe_n==0) AND (sleep==0) AND (a read was performed on the last edge). It follows oe_n and sleep without waiting for a clock. dout reads 0 while dout_en is 0.
- R10: While sleep is high, dout_en is 0, no access is performed, and the memory contents are kept.
- R11: Strobes are ignored while sleep is high and on the first 2 edges after sleep is sampled low. Each ignored strobe sets strobe_err high for the following cycle. A strobe on the third edge is accepted.
- R12: After reset, dout_en is 0, dout is 0 and strobe_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address |
| strb_cpu_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | First select, active low; also gates the processor strobe |
| sel_b | input | 1 | Second select, active high |
| sel_c_n | input | 1 | Third select, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data, 0 when not driven |
| dout_en | output | 1 | Output drive flag |
| strobe_err | output | 1 | Strobe rejected during sleep or wake-up |

## Verification
A burst counter that is off by one shows up one cycle after the access edge as the data of a neighbouring address. An error in the linear or interleaved order only shows once the burst wraps, so the bench runs full four-beat bursts in both orders. A broken write decode or lane mask shows only when the data is read back later, as lanes that were merged wrongly. A wrong wake-up count shows either as a strobe_err pulse on the wrong edge or as an access that went through when it should have been dropped.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  // Low two address bits of burst beat k from the base.
  function automatic logic [1:0] beat_lo(input logic [1:0] base,
                                         input logic [1:0] k,
                                         input logic       ilv);
    return ilv ? (base ^ k) : (base + k);
  endfunction

endpackage

// File: rtl/sbsram_burst_seq.sv
module sbsram_burst_seq
  import sbsram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] base_in,
  input  logic       advance,
  input  logic       order_ilv,
  output logic [1:0] lo_now
);

  logic [1:0] base_q, base_d;
  logic [1:0] cnt_q, cnt_d;
  logic       en;

  always_comb begin
    base_d = load ? base_in : base_q;
    if (load)         cnt_d = 2'd0;
    else if (advance) cnt_d = cnt_q + 2'd1;
    else              cnt_d = cnt_q;
    en     = load | advance;
    lo_now = beat_lo(base_d, cnt_d, order_ilv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= 2'd0;
      cnt_q  <= 2'd0;
    end else if (en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/sbsram_wdecode.sv
module sbsram_wdecode #(
  parameter int LANES = 4
) (
  input  logic             gwr_n,
  input  logic             bwr_n,
  input  logic [LANES-1:0] lane_we_n,
  output logic [LANES-1:0] lane_mask
);

  always_comb begin
    if (!gwr_n)      lane_mask = {LANES{1'b1}};
    else if (!bwr_n) lane_mask = ~lane_we_n;
    else             lane_mask = '0;
  end

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    rd_en,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_mask[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= mem[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core #(
  parameter int LANES    = 4,
  parameter int LANE_W   = 9,
  parameter int ADDR_W   = 8,
  parameter int WAKE_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    strb_cpu_n,
  input  logic                    strb_ctl_n,
  input  logic                    step_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    gwr_n,
  input  logic                    bwr_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic                    order_ilv,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en,
  output logic                    strobe_err
);

  localparam int DW     = LANES * LANE_W;
  localparam int HI_W   = ADDR_W - 2;
  localparam int WAKE_W = $clog2(WAKE_CYC + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  // state
  logic              burst_q, burst_d;
  logic              rd_live, rd_live_d;
  logic              err_q, err_d;
  logic [WAKE_W-1:0] wake_q, wake_d;
  logic [HI_W-1:0]   hi_q, hi_d;

  // decode
  logic              waking, blocked, any_strobe, cpu_take;
  logic              new_edge, selected, start, cont, advance;
  logic [LANES-1:0]  dec_mask, wr_mask;
  logic              rd_op;
  logic [1:0]        lo_now;
  logic [ADDR_W-1:0] acc_addr;
  logic [DW-1:0]     rdata;

  sbsram_wdecode #(.LANES(LANES)) u_wdec (
    .gwr_n     (gwr_n),
    .bwr_n     (bwr_n),
    .lane_we_n (lane_we_n),
    .lane_mask (dec_mask)
  );

  always_comb begin
    waking     = (wake_q != '0);
    blocked    = sleep | waking;
    any_strobe = ~strb_cpu_n | ~strb_ctl_n;
    cpu_take   = ~strb_cpu_n & ~sel_a_n;
    new_edge   = ~blocked & (cpu_take | ~strb_ctl_n);
    selected   = ~sel_a_n & sel_b & ~sel_c_n;
    start      = new_edge & selected;
    cont       = ~blocked & ~new_edge & burst_q;
    advance    = cont & ~step_n;

    if ((start & ~cpu_take) | cont) wr_mask = dec_mask;
    else                            wr_mask = '0;

    rd_op = (start & (cpu_take | (dec_mask == '0))) |
            (cont & (dec_mask == '0));
  end

  sbsram_burst_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load      (start),
    .base_in   (addr[1:0]),
    .advance   (advance),
    .order_ilv (order_ilv),
    .lo_now    (lo_now)
  );

  always_comb begin
    hi_d      = start ? addr[ADDR_W-1:2] : hi_q;
    acc_addr  = {hi_d, lo_now};
    burst_d   = new_edge ? selected : burst_q;
    rd_live_d = rd_op;
    err_d     = blocked & any_strobe;
    if (sleep)       wake_d = WAKE_W'(WAKE_CYC);
    else if (waking) wake_d = wake_q - WAKE_W'(1);
    else             wake_d = wake_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      burst_q <= 1'b0;
      rd_live <= 1'b0;
      err_q   <= 1'b0;
      wake_q  <= '0;
      hi_q    <= '0;
    end else begin
      burst_q <= burst_d;
      rd_live <= rd_live_d;
      err_q   <= err_d;
      wake_q  <= wake_d;
      if (start) hi_q <= hi_d;
    end
  end

  sbsram_array #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .addr    (acc_addr),
    .rd_en   (rd_op),
    .wr_mask (wr_mask),
    .wdata   (din),
    .rdata   (rdata)
  );

  assign dout_en    = rd_live & ~oe_n & ~sleep;
  assign dout       = dout_en ? rdata : '0;
  assign strobe_err = err_q;

endmodule

// File: rtl/sbsram_core_chk.sv
module sbsram_core_chk (
  input logic clk,
  input logic rst_n,
  input logic strb_cpu_n,
  input logic strb_ctl_n,
  input logic sel_a_n,
  input logic sel_b,
  input logic sel_c_n,
  input logic oe_n,
  input logic sleep,
  input logic dout_en,
  input logic strobe_err,
  input logic waking,
  input logic rd_live
);

  // R9
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!oe_n && !sleep));

  // R10
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_en);

  // R11
  wake_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> waking);

  // R11
  blocked_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sleep || waking) && !strb_ctl_n) |=> strobe_err);

  // R1
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !waking && !strb_ctl_n && !sel_b) |=> !rd_live);

  // R3
  cpu_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !waking && !strb_cpu_n && !sel_a_n && sel_b && !sel_c_n) |=> rd_live);

endmodule

bind sbsram_core sbsram_core_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .strb_cpu_n (strb_cpu_n),
  .strb_ctl_n (strb_ctl_n),
  .sel_a_n    (sel_a_n),
  .sel_b      (sel_b),
  .sel_c_n    (sel_c_n),
  .oe_n       (oe_n),
  .sleep      (sleep),
  .dout_en    (dout_en),
  .strobe_err (strobe_err),
  .waking     (waking),
  .rd_live    (rd_live)
);

// File: tb/sbsram_core_bench.sv
module sbsram_core_bench;

  localparam int LANES = 4;
  localparam int DW    = 36;

  logic clk, rst_n;
  logic [7:0] addr;
  logic strb_cpu_n, strb_ctl_n, step_n, sel_a_n, sel_b, sel_c_n;
  logic gwr_n, bwr_n, oe_n, sleep, order_ilv;
  logic [LANES-1:0] lane_we_n;
  logic [DW-1:0] din, dout;
  logic dout_en, strobe_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] ref_mem [256];

  sbsram_core u_sbsram_core (
    .clk(clk), .rst_n(rst_n), .addr(addr), .strb_cpu_n(strb_cpu_n),
    .strb_ctl_n(strb_ctl_n), .step_n(step_n), .sel_a_n(sel_a_n),
    .sel_b(sel_b), .sel_c_n(sel_c_n), .gwr_n(gwr_n), .bwr_n(bwr_n),
    .lane_we_n(lane_we_n), .oe_n(oe_n), .sleep(sleep),
    .order_ilv(order_ilv), .din(din), .dout(dout), .dout_en(dout_en),
    .strobe_err(strobe_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    strb_cpu_n = 1; strb_ctl_n = 1; step_n = 1;
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    gwr_n = 1; bwr_n = 1; lane_we_n = '1; din = '0;
  endtask

  function automatic logic [7:0] beat(logic [7:0] base, int k, logic ilv);
    logic [1:0] kk;
    kk = 2'(k);
    return {base[7:2], ilv ? (base[1:0] ^ kk) : (base[1:0] + kk)};
  endfunction

  // controller-strobe write burst of four beats, all lanes
  task automatic wr_burst(logic [7:0] base, logic ilv, logic [DW-1:0] seed);
    order_ilv = ilv;
    for (int k = 0; k < 4; k++) begin
      idle();
      gwr_n = 0;
      din = seed + DW'(k * 36'h111111111);
      if (k == 0) begin strb_ctl_n = 0; addr = base; end
      else step_n = 0;
      ref_mem[beat(base, k, ilv)] = din;
      tick();
    end
    idle();
  endtask

  // processor-strobe read burst of n beats with advance
  task automatic rd_burst(string tag, logic [7:0] base, logic ilv, int n);
    order_ilv = ilv;
    for (int k = 0; k < n; k++) begin
      idle();
      if (k == 0) begin strb_cpu_n = 0; addr = base; end
      else step_n = 0;
      tick();
      chk(tag, dout, ref_mem[beat(base, k, ilv)]);
    end
    idle();
  endtask

  task automatic t_reset();
    chk("R12 dout_en", 36'(dout_en), 36'd0);
    chk("R12 dout", dout, 36'd0);
    chk("R12 strobe_err", 36'(strobe_err), 36'd0);
  endtask

  task automatic t_linear();
    wr_burst(8'h10, 1'b0, 36'h0A1B2C3D4);
    rd_burst("R6 R7 linear wrap", 8'h10, 1'b0, 5);
    rd_burst("R7 linear mid start", 8'h12, 1'b0, 4);
  endtask

  task automatic t_interleave();
    wr_burst(8'h22, 1'b1, 36'h5E6F70819);
    rd_burst("R7 interleaved", 8'h21, 1'b1, 4);
    order_ilv = 0;
  endtask

  task automatic t_suspend();
    idle(); strb_cpu_n = 0; addr = 8'h10; tick();
    chk("R6 start", dout, ref_mem[8'h10]);
    idle(); tick();
    chk("R6 suspend", dout, ref_mem[8'h10]);
    idle(); step_n = 0; tick();
    chk("R6 advance", dout, ref_mem[8'h11]);
    idle();
  endtask

  task automatic t_adv_ignored();
    idle(); strb_cpu_n = 0; step_n = 0; addr = 8'h12; tick();
    chk("R8 advance on strobe", dout, ref_mem[8'h12]);
    idle();
  endtask

  task automatic t_cpu_read();
    idle(); strb_cpu_n = 0; gwr_n = 0; din = 36'hFFFFFFFFF; addr = 8'h13; tick();
    chk("R3 cpu start reads", dout, ref_mem[8'h13]);
    idle(); tick();
    idle(); strb_cpu_n = 0; addr = 8'h13; tick();
    chk("R3 array unchanged", dout, ref_mem[8'h13]);
    idle();
  endtask

  task automatic t_cpu_gated();
    idle(); strb_cpu_n = 0; addr = 8'h10; tick();
    idle(); strb_cpu_n = 0; sel_a_n = 1; step_n = 0; addr = 8'h40; tick();
    chk("R2 gated strobe continues", dout, ref_mem[8'h11]);
    idle();
  endtask

  task automatic t_bytes();
    logic [DW-1:0] b;
    idle(); strb_ctl_n = 0; gwr_n = 0; addr = 8'h30; din = 36'h123456789; tick();
    ref_mem[8'h30] = din;
    b = 36'hABCDEF012;
    idle(); strb_ctl_n = 0; bwr_n = 0; lane_we_n = 4'b1010; addr = 8'h30; din = b; tick();
    ref_mem[8'h30][8:0]   = b[8:0];
    ref_mem[8'h30][26:18] = b[26:18];
    idle(); strb_ctl_n = 0; lane_we_n = 4'b0000; addr = 8'h30; din = 36'h0; tick();
    chk("R4 byte enable high is read", dout, ref_mem[8'h30]);
    idle(); strb_ctl_n = 0; bwr_n = 0; addr = 8'h30; din = 36'h0; tick();
    chk("R4 no lane enabled is read", dout, ref_mem[8'h30]);
    idle(); strb_cpu_n = 0; addr = 8'h30; tick();
    chk("R5 lane merge", dout, ref_mem[8'h30]);
    idle();
  endtask

  task automatic t_deselect();
    idle(); strb_ctl_n = 0; gwr_n = 0; addr = 8'h40; din = 36'h0E0E0E0E0; tick();
    ref_mem[8'h40] = din;
    idle(); strb_ctl_n = 0; gwr_n = 0; sel_c_n = 1; addr = 8'h40; din = 36'h0F0F0F0F0; tick();
    chk("R1 bad select write no drive", 36'(dout_en), 36'd0);
    idle(); strb_ctl_n = 0; sel_b = 0; addr = 8'h40; tick();
    chk("R1 bad select read no drive", 36'(dout_en), 36'd0);
    idle(); strb_cpu_n = 0; addr = 8'h40; tick();
    chk("R1 no write while deselected", dout, ref_mem[8'h40]);
    idle();
  endtask

  task automatic t_oe();
    idle(); strb_cpu_n = 0; addr = 8'h10; tick();
    chk("R9 drive on", 36'(dout_en), 36'd1);
    oe_n = 1; #1;
    chk("R9 oe off", 36'(dout_en), 36'd0);
    chk("R9 dout zero", dout, 36'd0);
    oe_n = 0; #1;
    chk("R9 oe back", dout, ref_mem[8'h10]);
    idle(); tick();
  endtask

  task automatic t_sleep();
    idle(); strb_ctl_n = 0; gwr_n = 0; addr = 8'h50; din = 36'h777788889; tick();
    ref_mem[8'h50] = din;
    idle(); strb_cpu_n = 0; addr = 8'h50; tick();
    sleep = 1; #1;
    chk("R10 sleep drops drive", 36'(dout_en), 36'd0);
    idle(); tick();
    idle(); strb_ctl_n = 0; gwr_n = 0; addr = 8'h50; din = 36'h0; tick();
    chk("R11 strobe in sleep flagged", 36'(strobe_err), 36'd1);
    idle(); tick();
    chk("R11 flag clears", 36'(strobe_err), 36'd0);
    sleep = 0;
    idle(); strb_ctl_n = 0; gwr_n = 0; addr = 8'h50; din = 36'h0; tick();
    chk("R11 wake edge 1 flagged", 36'(strobe_err), 36'd1);
    idle(); strb_ctl_n = 0; gwr_n = 0; addr = 8'h50; din = 36'h0; tick();
    chk("R11 wake edge 2 flagged", 36'(strobe_err), 36'd1);
    idle(); strb_cpu_n = 0; addr = 8'h50; tick();
    chk("R11 edge 3 accepted", 36'(strobe_err), 36'd0);
    chk("R10 contents kept", dout, ref_mem[8'h50]);
    idle();
  endtask

  initial begin
    idle(); addr = '0; oe_n = 0; sleep = 0; order_ilv = 0; rst_n = 0;
    repeat (3) tick();
    t_reset();
    rst_n = 1;
    repeat (3) tick();
    t_reset();
    t_linear();
    t_interleave();
    t_suspend();
    t_adv_ignored();
    t_cpu_read();
    t_cpu_gated();
    t_bytes();
    t_deselect();
    t_oe();
    t_sleep();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog (all R) act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule